// File: doc/BRIEF.md
# Serially Configured Pad Control Chain

This block places one control cell beside each user I/O pad and loads all of them through a single serial path. A loader provides a data bit, a shift enable, a load strobe and an active-low reset, all on one serial clock. Every cell holds a shift stage and an active copy of its settings. The shift stages are daisy-chained: pad 0 takes the loader's data bit and passes its top bit to pad 1, and so on up the chain. The top bit of the last pad comes back out as `ser_dout`.

Pad settings change only when the load strobe copies every shift stage into its active register at once. A shift alone never disturbs the pads. Each cell's active settings give the pad's drive mode and its input disable. They also choose the owner of the pad's output value and output enable, which is either the management port or the user port. The pad input, gated by the input disable, is returned to both sides.

The lowest `MGMT_PADS` pads are full bidirectional management pads with their own management output and output-enable inputs. On the remaining pads, management mode loops the gated pad input back to the pad output, and the output enable comes from the stored settings.

Top module: `pad_cfg_chain`

## Requirements
- R1: While `ser_rst_n` is low at a rising edge, every cell's shift stage and active register return to their defaults, whatever was loaded before. Management pads default to drive mode 3'b110 with management ownership and input enabled. Every other pad defaults to drive mode 3'b001 with management ownership, stored output enable inactive (1) and input enabled.
- R2: The settings of each cell are `CFG_BITS` wide. Bit 0 selects the owner (1 = user port, 0 = management port). Bit 1 is the stored active-low output enable. Bit 2 is the input disable (1 = disabled). Bits 5:3 are the drive mode.
- R3: At each rising edge with `ser_shift` high, every shift stage moves up one bit: bit 0 takes the previous cell's top bit, or `ser_din` for pad 0. `ser_dout` always shows the top bit of the last pad's shift stage.
- R4: After `NUM_PADS*CFG_BITS` shifts, stream bit j (j = 0 first) sits in pad NUM_PADS-1-j/CFG_BITS at bit CFG_BITS-1-(j mod CFG_BITS). The host therefore sends the last pad's top bit first and pad 0's bit 0 last.
- R5: `pad_dm`, `pad_in_dis` and the ownership choice do not change at any edge where `ser_load` is low and reset is not applied, even while bits are being shifted.
- R6: At an edge with `ser_load` high, every active register takes the contents its shift stage held before that edge. The pad outputs show the new settings right after that edge.
- R7: On a pad owned by the user port, `pad_out` follows `usr_out` and `pad_oe_n` follows `usr_oe_n`.
- R8: On a management-owned management pad, `pad_out` follows `mgmt_out` and `pad_oe_n` follows `mgmt_oe_n`.
- R9: On a management-owned pad above the management pads, `pad_out` equals that pad's `mgmt_in` (the gated pad input) and `pad_oe_n` equals stored bit 1.
- R10: `usr_in` and `mgmt_in` of a pad both equal `pad_in` when its input disable is 0, and are 0 when it is 1. `pad_in_dis` shows the stored bit 2 and `pad_dm` shows bits 5:3 at position 3*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial loader clock |
| ser_rst_n | input | 1 | Synchronous active-low reset to default settings |
| ser_shift | input | 1 | Shift enable for the whole chain |
| ser_load | input | 1 | Copies every shift stage into its active register |
| ser_din | input | 1 | Serial data into pad 0 |
| ser_dout | output | 1 | Top bit of the last pad's shift stage |
| mgmt_out | input | MGMT_PADS | Management output value for the management pads |
| mgmt_oe_n | input | MGMT_PADS | Management active-low output enable for the management pads |
| mgmt_in | output | NUM_PADS | Gated pad input to the management side |
| usr_out | input | NUM_PADS | User output value |
| usr_oe_n | input | NUM_PADS | User active-low output enable |
| usr_in | output | NUM_PADS | Gated pad input to the user side |
| pad_in | input | NUM_PADS | Value read from the pad |
| pad_out | output | NUM_PADS | Value driven to the pad |
| pad_oe_n | output | NUM_PADS | Active-low pad output enable |
| pad_in_dis | output | NUM_PADS | Pad input disable |
| pad_dm | output | 3*NUM_PADS | Drive mode, 3 bits per pad |

## Verification
The assertions assume a few things about the inputs. `ser_shift` and `ser_load` matter only while `ser_rst_n` is high. A load compares the active registers with the shift stages one edge earlier, so no reset may fall between the two. Inputs must be steady around each rising edge.

The stimulus changes every input on the falling clock edge and samples one time unit after the rising edge. It gives each reset at least two clock edges. Each full chain load is followed by a separate load strobe, with shifting stopped, so the window checks always see a clean load.

// File: rtl/pcc_pkg.sv
// Package for the pad control chain.
// Holds the positions of the per-cell settings fields and the reset
// defaults. Assumes each cell's settings are at least FIELD_BITS wide.
package pcc_pkg;
    localparam int FIELD_BITS = 6;
    localparam int F_OWN      = 0;   // 1 = user port owns the pad
    localparam int F_OEN      = 1;   // stored active-low output enable
    localparam int F_IDIS     = 2;   // input disable
    localparam int F_DM       = 3;   // drive mode, 3 bits
    localparam int DM_W       = 3;

    // Reset value of the field bits, by pad type.
    function automatic logic [FIELD_BITS-1:0] dflt_fields(input logic full_bidir);
        if (full_bidir)
            dflt_fields = 6'b110_0_0_0;
        else
            dflt_fields = 6'b001_0_1_0;
    endfunction
endpackage

// File: rtl/pcc_cell_reg.sv
// One pad's settings storage: a shift stage in the serial chain and an
// active copy that changes only on the load strobe.
// Assumes a synchronous active-low reset on the serial clock, and CFG_BITS >= 2.
module pcc_cell_reg #(
    parameter int CFG_BITS = 6,
    parameter logic [CFG_BITS-1:0] RST_VAL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                load,
    input  logic                sin,
    output logic                sout,
    output logic [CFG_BITS-1:0] shadow,
    output logic [CFG_BITS-1:0] active
);
    // Shift stage: move up one bit per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= RST_VAL;
        else if (shift_en)
            shadow <= {shadow[CFG_BITS-2:0], sin};
    end

    // Active copy: take the shift stage only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= RST_VAL;
        else if (load)
            active <= shadow;
    end

    // The top bit feeds the next cell in the chain.
    assign sout = shadow[CFG_BITS-1];
endmodule

// File: rtl/pcc_pad_steer.sv
// Steering for one pad. Picks the owner of the output value and the
// output enable, and gates the pad input returned to both sides.
// Assumes the caller has already formed the management-side drive.
module pcc_pad_steer (
    input  logic user_own,
    input  logic in_dis,
    input  logic mgmt_drv,
    input  logic mgmt_oen,
    input  logic usr_drv,
    input  logic usr_oen,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe_n,
    output logic gated_in
);
    // Input gating, then the ownership mux.
    always_comb begin
        gated_in = pad_in & ~in_dis;
        pad_out  = user_own ? usr_drv : mgmt_drv;
        pad_oe_n = user_own ? usr_oen : mgmt_oen;
    end
endmodule

// File: rtl/pad_cfg_chain.sv
// Top of the pad control chain. It holds NUM_PADS cells on one serial
// chain. Pad 0 takes ser_din and the last pad drives ser_dout. The lowest
// MGMT_PADS pads are full bidirectional management pads. The rest loop
// the gated input back as their management output.
// Assumes MGMT_PADS <= NUM_PADS and CFG_BITS >= FIELD_BITS.
module pad_cfg_chain #(
    parameter int NUM_PADS  = 6,
    parameter int MGMT_PADS = 2,
    parameter int CFG_BITS  = 6
) (
    input  logic                  ser_clk,
    input  logic                  ser_rst_n,
    input  logic                  ser_shift,
    input  logic                  ser_load,
    input  logic                  ser_din,
    output logic                  ser_dout,
    input  logic [MGMT_PADS-1:0]  mgmt_out,
    input  logic [MGMT_PADS-1:0]  mgmt_oe_n,
    output logic [NUM_PADS-1:0]   mgmt_in,
    input  logic [NUM_PADS-1:0]   usr_out,
    input  logic [NUM_PADS-1:0]   usr_oe_n,
    output logic [NUM_PADS-1:0]   usr_in,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe_n,
    output logic [NUM_PADS-1:0]   pad_in_dis,
    output logic [3*NUM_PADS-1:0] pad_dm
);
    import pcc_pkg::*;

    localparam int CHAIN_LEN = NUM_PADS * CFG_BITS;

    logic [NUM_PADS:0]    link;
    logic [CHAIN_LEN-1:0] shf_flat;
    logic [CHAIN_LEN-1:0] act_flat;

    assign link[0]  = ser_din;
    assign ser_dout = link[NUM_PADS];

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        localparam logic [CFG_BITS-1:0] RV = CFG_BITS'(dflt_fields(i < MGMT_PADS));
        localparam int BASE = i * CFG_BITS;

        logic m_drv;
        logic m_oen;

        pcc_cell_reg #(
            .CFG_BITS (CFG_BITS),
            .RST_VAL  (RV)
        ) u_cell (
            .clk      (ser_clk),
            .rst_n    (ser_rst_n),
            .shift_en (ser_shift),
            .load     (ser_load),
            .sin      (link[i]),
            .sout     (link[i+1]),
            .shadow   (shf_flat[BASE +: CFG_BITS]),
            .active   (act_flat[BASE +: CFG_BITS])
        );

        // Management-side drive depends on the pad type.
        if (i < MGMT_PADS) begin : g_bidir
            assign m_drv = mgmt_out[i];
            assign m_oen = mgmt_oe_n[i];
        end else begin : g_loop
            assign m_drv = mgmt_in[i];
            assign m_oen = act_flat[BASE + F_OEN];
        end

        pcc_pad_steer u_steer (
            .user_own (act_flat[BASE + F_OWN]),
            .in_dis   (act_flat[BASE + F_IDIS]),
            .mgmt_drv (m_drv),
            .mgmt_oen (m_oen),
            .usr_drv  (usr_out[i]),
            .usr_oen  (usr_oe_n[i]),
            .pad_in   (pad_in[i]),
            .pad_out  (pad_out[i]),
            .pad_oe_n (pad_oe_n[i]),
            .gated_in (mgmt_in[i])
        );

        assign usr_in[i]              = mgmt_in[i];
        assign pad_in_dis[i]          = act_flat[BASE + F_IDIS];
        assign pad_dm[3*i +: DM_W]    = act_flat[BASE + F_DM +: DM_W];
    end
endmodule

// File: rtl/pcc_chain_chk.sv
// Checker for the pad control chain, bound to every instance of the top.
// Assumes the serial controls matter only while reset is high.
module pcc_chain_chk #(
    parameter int NUM_PADS  = 6,
    parameter int MGMT_PADS = 2,
    parameter int CFG_BITS  = 6
) (
    input logic                           ser_clk,
    input logic                           ser_rst_n,
    input logic                           ser_load,
    input logic [NUM_PADS-1:0]            mgmt_in,
    input logic [NUM_PADS-1:0]            usr_in,
    input logic [NUM_PADS-1:0]            usr_out,
    input logic [NUM_PADS-1:0]            usr_oe_n,
    input logic [NUM_PADS-1:0]            pad_out,
    input logic [NUM_PADS-1:0]            pad_oe_n,
    input logic [NUM_PADS-1:0]            pad_in_dis,
    input logic [3*NUM_PADS-1:0]          pad_dm,
    input logic [NUM_PADS*CFG_BITS-1:0]   shf_flat,
    input logic [NUM_PADS*CFG_BITS-1:0]   act_flat
);
    // Expected drive modes of all pads right after reset.
    function automatic logic [3*NUM_PADS-1:0] dm_after_reset();
        logic [3*NUM_PADS-1:0] v;
        logic [5:0] f;
        v = '0;
        for (int i = 0; i < NUM_PADS; i++) begin
            f = pcc_pkg::dflt_fields(i < MGMT_PADS);
            v[3*i +: 3] = f[5:3];
        end
        return v;
    endfunction

    localparam logic [3*NUM_PADS-1:0] DM_RST = dm_after_reset();

    // R1: drive modes are at their defaults when reset ends
    a_r1_reset_dm: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        $rose(ser_rst_n) |-> pad_dm == DM_RST);

    // R5: without a load, the pad settings stay where they are
    a_r5_hold: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        (!$past(ser_load) && $past(ser_rst_n)) |->
        ($stable(pad_dm) && $stable(pad_in_dis) && $stable(act_flat)));

    // R6: a load copies the shift stages as they stood before the edge
    a_r6_load_copy: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        ($past(ser_load) && $past(ser_rst_n)) |-> act_flat == $past(shf_flat));

    // R10: a disabled input never reaches either side
    a_r10_gate: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        ((mgmt_in & pad_in_dis) == '0) && ((usr_in & pad_in_dis) == '0));

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_own
        // R7: a user-owned pad follows the user port
        a_r7_user_drive: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
            act_flat[i*CFG_BITS + pcc_pkg::F_OWN] |->
            (pad_out[i] == usr_out[i]) && (pad_oe_n[i] == usr_oe_n[i]));
    end
endmodule

bind pad_cfg_chain pcc_chain_chk #(
    .NUM_PADS  (NUM_PADS),
    .MGMT_PADS (MGMT_PADS),
    .CFG_BITS  (CFG_BITS)
) u_chk (.*);

// File: tb/pad_cfg_chain_tb.sv
// Bench for the pad control chain. It sweeps many settings patterns and
// input patterns. Expected values come from the requirement formulas.
module pad_cfg_chain_tb;
    localparam int NP  = 6;
    localparam int MG  = 2;
    localparam int CB  = 6;
    localparam int LEN = NP * CB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sh = 1'b0;
    logic            ld = 1'b0;
    logic            din = 1'b0;
    logic            dout;
    logic [MG-1:0]   m_out = '0;
    logic [MG-1:0]   m_oen = '0;
    logic [NP-1:0]   m_in;
    logic [NP-1:0]   u_out = '0;
    logic [NP-1:0]   u_oen = '0;
    logic [NP-1:0]   u_in;
    logic [NP-1:0]   p_in = '0;
    logic [NP-1:0]   p_out;
    logic [NP-1:0]   p_oen;
    logic [NP-1:0]   p_idis;
    logic [3*NP-1:0] p_dm;

    int total = 0;
    int bad = 0;
    logic [5:0] cur [NP];

    always #5 clk = ~clk;

    pad_cfg_chain #(.NUM_PADS(NP), .MGMT_PADS(MG), .CFG_BITS(CB)) u_dut (
        .ser_clk(clk), .ser_rst_n(rst_n), .ser_shift(sh), .ser_load(ld),
        .ser_din(din), .ser_dout(dout),
        .mgmt_out(m_out), .mgmt_oe_n(m_oen), .mgmt_in(m_in),
        .usr_out(u_out), .usr_oe_n(u_oen), .usr_in(u_in),
        .pad_in(p_in), .pad_out(p_out), .pad_oe_n(p_oen),
        .pad_in_dis(p_idis), .pad_dm(p_dm)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [5:0] dflt(input int k);
        return (k < MG) ? 6'b110000 : 6'b001010;
    endfunction

    task automatic set_dflt();
        for (int k = 0; k < NP; k++) cur[k] = dflt(k);
    endtask

    // Compare every pad-facing and returned output with the model in cur.
    task automatic check_outputs(input string tag);
        logic [NP-1:0] e_out, e_oen, e_idis, e_in;
        logic [3*NP-1:0] e_dm;
        for (int k = 0; k < NP; k++) begin
            e_in[k]   = cur[k][2] ? 1'b0 : p_in[k];
            e_idis[k] = cur[k][2];
            e_dm[3*k +: 3] = cur[k][5:3];
            if (cur[k][0]) begin
                e_out[k] = u_out[k];
                e_oen[k] = u_oen[k];
            end else if (k < MG) begin
                e_out[k] = m_out[k];
                e_oen[k] = m_oen[k];
            end else begin
                e_out[k] = e_in[k];
                e_oen[k] = cur[k][1];
            end
        end
        chk(p_dm == e_dm, "R10", {tag, " pad_dm"}, 32'(p_dm), 32'(e_dm));
        chk(p_idis == e_idis, "R10", {tag, " pad_in_dis"}, 32'(p_idis), 32'(e_idis));
        chk(m_in == e_in && u_in == e_in, "R10", {tag, " returned input"},
            32'({m_in, u_in}), 32'({e_in, e_in}));
        chk(p_out == e_out, "R7 R8 R9", {tag, " pad_out"}, 32'(p_out), 32'(e_out));
        chk(p_oen == e_oen, "R7 R8 R9", {tag, " pad_oe_n"}, 32'(p_oen), 32'(e_oen));
    endtask

    task automatic drive_inputs(input int p, input int seed);
        @(negedge clk);
        p_in  = NP'(p * 5 + seed);
        u_out = NP'(p * 3 + 1);
        u_oen = NP'(~(p * 7));
        m_out = MG'(p);
        m_oen = MG'(p >> 1);
        #1;
    endtask

    // Shift a full stream for cfg, checking the hold rule, then load it.
    task automatic load_cfg(input logic [5:0] cfg [NP]);
        logic [3*NP-1:0] dm_before;
        dm_before = p_dm;
        for (int j = 0; j < LEN; j++) begin
            @(negedge clk);
            sh  = 1'b1;
            din = cfg[NP-1 - j / CB][CB-1 - j % CB];
            step();
            if (j % CB == 0)
                chk(p_dm == dm_before, "R5", "dm during shift", 32'(p_dm), 32'(dm_before));
        end
        @(negedge clk);
        sh = 1'b0;
        din = 1'b0;
        #1;
        chk(p_dm == dm_before, "R5", "dm after shift no load", 32'(p_dm), 32'(dm_before));
        @(negedge clk);
        ld = 1'b1;
        step();
        @(negedge clk);
        ld = 1'b0;
        for (int k = 0; k < NP; k++) cur[k] = cfg[k];
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] cfg [NP];
        // R1: reset state
        m_oen = 2'b10;
        step();
        step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        set_dflt();
        check_outputs("R1 reset");

        // R3: the chain shifts out the reset contents, last pad's top bit first
        for (int j = 0; j < LEN; j++) begin
            logic [5:0] d;
            d = dflt(NP-1 - j / CB);
            chk(dout == d[CB-1 - j % CB], "R3", "ser_dout stream", 32'(dout),
                32'(d[CB-1 - j % CB]));
            @(negedge clk);
            sh = 1'b1;
            din = 1'b0;
            step();
        end
        @(negedge clk);
        sh = 1'b0;
        #1;
        chk(dout == 1'b0, "R3", "ser_dout after flush", 32'(dout), 0);
        check_outputs("R5 no load");

        // R2 R4 R6: sweep settings patterns, then input patterns
        for (int seed = 0; seed < 16; seed++) begin
            for (int k = 0; k < NP; k++)
                cfg[k] = 6'((seed * 37 + k * 13 + seed * k * 5) & 63);
            load_cfg(cfg);
            #1;
            check_outputs("R4 R6 after load");
            for (int p = 0; p < 8; p++) begin
                drive_inputs(p, seed);
                check_outputs("R2 sweep");
            end
        end

        // R8 R9: all pads owned by management, inputs enabled
        for (int k = 0; k < NP; k++) cfg[k] = {3'(k), 1'b0, 1'(k), 1'b0};
        load_cfg(cfg);
        for (int p = 0; p < 16; p++) begin
            drive_inputs(p, 3);
            check_outputs("R8 R9 mgmt");
        end

        // R7: all pads owned by the user port
        for (int k = 0; k < NP; k++) cfg[k] = {3'(7 - k), 1'b0, 1'b1, 1'b1};
        load_cfg(cfg);
        for (int p = 0; p < 16; p++) begin
            drive_inputs(p, 9);
            check_outputs("R7 user");
        end

        // R1: reset after the user has taken the pads
        @(negedge clk);
        rst_n = 1'b0;
        step();
        step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        set_dflt();
        check_outputs("R1 reset after load");
        chk(dout == dflt(NP-1)[CB-1], "R1", "shift stage reset", 32'(dout),
            32'(dflt(NP-1)[CB-1]));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule